// File: doc/BRIEF.md
# Doubly Linked Sharer List Manager

This block does the sharer bookkeeping for a coherence scheme in which the record of who holds a line is spread across the caches. It does not use a bit vector at home. Each cache entry for a line holds a forward pointer and a backward pointer. The home side holds one head pointer per line. Together these form a doubly linked list of every cache that holds a copy. The block models both stores, the home head table and the per-cache link storage, for a parameterised number of caches and lines.

Three operations are issued on one request port:
- **Insert** places a new sharer in front of the current first element.
- **Delete** unlinks a sharer in place by joining its two neighbours.
- **Invalidate** walks the list from the head, one node per clock. It reports each visited cache and empties the list.

A query port reads the head of any line and the links of any cache, so the list can be observed from outside. Message transport and data movement are handled elsewhere.

A pointer is the cache index with one extra most significant bit. When that bit is set, the pointer is null: it marks an empty head or the end of the list. With the default of four caches the pointer is 3 bits wide and null reads as 4.

Top module: `sl_list_mgr`

## Requirements
- R1: After reset, every head pointer and every cache link reads null (value 4 with 4 caches), no cache is a member, `op_ready` is 1, and `done` and `visit_valid` are 0.
- R2: An insert of cache c on line L, where c is not a member, has four effects:
  - c becomes the head of L.
  - c's forward pointer takes the previous head value.
  - c's backward pointer is null.
  - If there was a previous head, that head's backward pointer becomes c.
- R3: An insert of a cache that is already a member of the line leaves the head and all links of that line unchanged.
- R4: A delete of member c joins its neighbours: the predecessor's forward pointer becomes c's successor, the successor's backward pointer becomes c's predecessor, and c's links become null with membership cleared.
- R5: A delete of the first element loads the head with that element's successor, which is null when it was the only member.
- R6: A delete of a cache that is not a member of the line changes nothing.
- R7: An invalidate of a non-empty line sets `visit_valid` for exactly one cycle per member, starting in the cycle after acceptance. `visit_cache` presents the members in list order from the head.
- R8: After an invalidate completes, the head of that line is null and no cache is a member of it.
- R9: `op_ready` is 0 during every visit cycle. An operation offered then is neither accepted nor applied.
- R10: `done` is 1 for one cycle in each of these cases:
  - the cycle after an accepted insert or delete, including the no-effect cases;
  - the cycle after the last visit of an invalidate;
  - the cycle after an invalidate of an empty line, which produces no visits.

  A new operation may be accepted in a cycle where `done` is 1.
- R11: Operations on one line leave the head and links of every other line unchanged.
- R12: Operation codes on `op_kind` are 1 = insert, 2 = delete, 3 = invalidate. Code 0 is never accepted and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is offered |
| op_kind | input | 2 | Operation code: 1 insert, 2 delete, 3 invalidate |
| op_line | input | clog2(N_LINES) | Line the operation targets |
| op_cache | input | clog2(N_CACHES) | Cache the insert or delete names |
| op_ready | output | 1 | The block can accept an operation this cycle |
| done | output | 1 | Completion pulse |
| visit_valid | output | 1 | A list node is being invalidated this cycle |
| visit_cache | output | clog2(N_CACHES) | Cache visited this cycle |
| q_line | input | clog2(N_LINES) | Query line |
| q_cache | input | clog2(N_CACHES) | Query cache |
| q_head | output | clog2(N_CACHES)+1 | Head pointer of the query line |
| q_fwd | output | clog2(N_CACHES)+1 | Forward pointer of the query cache on the query line |
| q_bwd | output | clog2(N_CACHES)+1 | Backward pointer of the query cache on the query line |
| q_member | output | 1 | The query cache is on the query line's list |

## Verification
Two events can share a clock cycle.

The first pair is completion and acceptance. The `done` pulse of one operation can coincide with the acceptance of the next. The bench issues operations back to back with no idle cycle, then checks that each one completes and that the resulting lists match a list model kept in the bench.

The second pair is a traversal visit and a newly offered operation. The bench offers an insert on another line during the visit cycles of an invalidate. It checks that `op_ready` stays low and that the other line is unchanged once the walk has finished.

// File: rtl/sl_pkg.sv
package sl_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_INSERT = 2'b01,
    OP_DELETE = 2'b10,
    OP_INVAL  = 2'b11
  } sl_op_e;
endpackage

// File: rtl/sl_head_table.sv
module sl_head_table #(
  parameter int N_LINES = 4,
  parameter int LW      = 2,
  parameter int PW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_line,
  input  logic [PW-1:0] wr_val,
  input  logic [LW-1:0] rd_line_a,
  output logic [PW-1:0] rd_a,
  input  logic [LW-1:0] rd_line_b,
  output logic [PW-1:0] rd_b
);
  localparam logic [PW-1:0] NULLP = {1'b1, {(PW-1){1'b0}}};

  logic [PW-1:0] head_q [N_LINES];

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic hit;
    assign hit = wr_en && (wr_line == LW'(l));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   head_q[l] <= NULLP;
      else if (hit) head_q[l] <= wr_val;
    end
  end

  assign rd_a = head_q[rd_line_a];
  assign rd_b = head_q[rd_line_b];
endmodule

// File: rtl/sl_link_store.sv
module sl_link_store #(
  parameter int N_LINES  = 4,
  parameter int N_CACHES = 4,
  parameter int LW       = 2,
  parameter int CW       = 2,
  parameter int PW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  // whole-entry write: both links and membership
  input  logic          ent_en,
  input  logic [LW-1:0] ent_line,
  input  logic [CW-1:0] ent_idx,
  input  logic [PW-1:0] ent_fwd,
  input  logic [PW-1:0] ent_bwd,
  input  logic          ent_mem,
  // forward link write
  input  logic          fw_en,
  input  logic [LW-1:0] fw_line,
  input  logic [CW-1:0] fw_idx,
  input  logic [PW-1:0] fw_val,
  // backward link write
  input  logic          bw_en,
  input  logic [LW-1:0] bw_line,
  input  logic [CW-1:0] bw_idx,
  input  logic [PW-1:0] bw_val,
  // read ports
  input  logic [LW-1:0] ra_line,
  input  logic [CW-1:0] ra_idx,
  output logic [PW-1:0] ra_fwd,
  output logic [PW-1:0] ra_bwd,
  output logic          ra_mem,
  input  logic [LW-1:0] rb_line,
  input  logic [CW-1:0] rb_idx,
  output logic [PW-1:0] rb_fwd,
  output logic [PW-1:0] rb_bwd,
  output logic          rb_mem
);
  localparam logic [PW-1:0] NULLP = {1'b1, {(PW-1){1'b0}}};

  logic [PW-1:0] fwd_q [N_LINES][N_CACHES];
  logic [PW-1:0] bwd_q [N_LINES][N_CACHES];
  logic          mem_q [N_LINES][N_CACHES];

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    for (genvar c = 0; c < N_CACHES; c++) begin : g_cache
      logic hit_e, hit_f, hit_b;
      assign hit_e = ent_en && (ent_line == LW'(l)) && (ent_idx == CW'(c));
      assign hit_f = fw_en  && (fw_line  == LW'(l)) && (fw_idx  == CW'(c));
      assign hit_b = bw_en  && (bw_line  == LW'(l)) && (bw_idx  == CW'(c));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fwd_q[l][c] <= NULLP;
          bwd_q[l][c] <= NULLP;
          mem_q[l][c] <= 1'b0;
        end else begin
          if (hit_e)      fwd_q[l][c] <= ent_fwd;
          else if (hit_f) fwd_q[l][c] <= fw_val;
          if (hit_e)      bwd_q[l][c] <= ent_bwd;
          else if (hit_b) bwd_q[l][c] <= bw_val;
          if (hit_e)      mem_q[l][c] <= ent_mem;
        end
      end
    end
  end

  assign ra_fwd = fwd_q[ra_line][ra_idx];
  assign ra_bwd = bwd_q[ra_line][ra_idx];
  assign ra_mem = mem_q[ra_line][ra_idx];
  assign rb_fwd = fwd_q[rb_line][rb_idx];
  assign rb_bwd = bwd_q[rb_line][rb_idx];
  assign rb_mem = mem_q[rb_line][rb_idx];
endmodule

// File: rtl/sl_walker.sv
module sl_walker #(
  parameter int LW = 2,
  parameter int CW = 2,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] start_line,
  input  logic [PW-1:0] start_head,
  input  logic [PW-1:0] nxt_ptr,
  output logic          busy,
  output logic [LW-1:0] line,
  output logic [CW-1:0] cur,
  output logic          finish
);
  logic          busy_q, busy_d;
  logic [LW-1:0] line_q, line_d;
  logic [CW-1:0] cur_q,  cur_d;

  always_comb begin
    busy_d = busy_q;
    line_d = line_q;
    cur_d  = cur_q;
    if (start) begin
      busy_d = 1'b1;
      line_d = start_line;
      cur_d  = start_head[CW-1:0];
    end else if (busy_q) begin
      if (nxt_ptr[PW-1]) busy_d = 1'b0;
      else               cur_d  = nxt_ptr[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      line_q <= '0;
      cur_q  <= '0;
    end else begin
      busy_q <= busy_d;
      line_q <= line_d;
      cur_q  <= cur_d;
    end
  end

  assign busy   = busy_q;
  assign line   = line_q;
  assign cur    = cur_q;
  assign finish = busy_q && nxt_ptr[PW-1];
endmodule

// File: rtl/sl_list_mgr.sv
module sl_list_mgr
  import sl_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int N_LINES  = 4,
  localparam int CW = (N_CACHES > 1) ? $clog2(N_CACHES) : 1,
  localparam int LW = (N_LINES  > 1) ? $clog2(N_LINES)  : 1,
  localparam int PW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [LW-1:0] op_line,
  input  logic [CW-1:0] op_cache,
  output logic          op_ready,
  output logic          done,
  output logic          visit_valid,
  output logic [CW-1:0] visit_cache,
  input  logic [LW-1:0] q_line,
  input  logic [CW-1:0] q_cache,
  output logic [PW-1:0] q_head,
  output logic [PW-1:0] q_fwd,
  output logic [PW-1:0] q_bwd,
  output logic          q_member
);
  localparam logic [PW-1:0] NULLP = {1'b1, {CW{1'b0}}};

  sl_op_e        kind;
  logic          accept;
  logic          walk_busy, walk_finish, walk_start;
  logic [LW-1:0] walk_line;
  logic [CW-1:0] walk_cur;
  logic [PW-1:0] head_rd;
  logic [LW-1:0] rd_line_a;
  logic [CW-1:0] rd_idx_a;
  logic [PW-1:0] rd_fwd_a, rd_bwd_a;
  logic          rd_mem_a;
  logic          hd_en;
  logic [LW-1:0] hd_line;
  logic [PW-1:0] hd_val;
  logic          ent_en, ent_mem;
  logic [LW-1:0] ent_line;
  logic [CW-1:0] ent_idx;
  logic [PW-1:0] ent_fwd, ent_bwd;
  logic          fw_en, bw_en;
  logic [CW-1:0] fw_idx, bw_idx;
  logic [PW-1:0] fw_val, bw_val;
  logic          done_q, done_d;

  assign kind      = sl_op_e'(op_kind);
  assign accept    = op_valid && !walk_busy && (kind != OP_NONE);
  assign rd_line_a = walk_busy ? walk_line : op_line;
  assign rd_idx_a  = walk_busy ? walk_cur  : op_cache;

  always_comb begin
    walk_start = 1'b0;
    hd_en      = 1'b0;
    hd_line    = op_line;
    hd_val     = NULLP;
    ent_en     = 1'b0;
    ent_line   = rd_line_a;
    ent_idx    = rd_idx_a;
    ent_fwd    = NULLP;
    ent_bwd    = NULLP;
    ent_mem    = 1'b0;
    fw_en      = 1'b0;
    fw_idx     = rd_bwd_a[CW-1:0];
    fw_val     = rd_fwd_a;
    bw_en      = 1'b0;
    bw_idx     = rd_fwd_a[CW-1:0];
    bw_val     = rd_bwd_a;
    done_d     = walk_finish;
    if (walk_busy) begin
      ent_en  = 1'b1;
      hd_line = walk_line;
      hd_en   = walk_finish;
    end else if (accept) begin
      unique case (kind)
        OP_INSERT: begin
          done_d = 1'b1;
          if (!rd_mem_a) begin
            ent_en  = 1'b1;
            ent_fwd = head_rd;
            ent_mem = 1'b1;
            hd_en   = 1'b1;
            hd_val  = {1'b0, op_cache};
            bw_en   = !head_rd[PW-1];
            bw_idx  = head_rd[CW-1:0];
            bw_val  = {1'b0, op_cache};
          end
        end
        OP_DELETE: begin
          done_d = 1'b1;
          if (rd_mem_a) begin
            ent_en = 1'b1;
            hd_en  = rd_bwd_a[PW-1];
            hd_val = rd_fwd_a;
            fw_en  = !rd_bwd_a[PW-1];
            bw_en  = !rd_fwd_a[PW-1];
          end
        end
        OP_INVAL: begin
          walk_start = !head_rd[PW-1];
          done_d     = head_rd[PW-1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  sl_head_table #(.N_LINES(N_LINES), .LW(LW), .PW(PW)) u_head (
    .clk(clk), .rst_n(rst_n),
    .wr_en(hd_en), .wr_line(hd_line), .wr_val(hd_val),
    .rd_line_a(op_line), .rd_a(head_rd),
    .rd_line_b(q_line),  .rd_b(q_head)
  );

  sl_link_store #(.N_LINES(N_LINES), .N_CACHES(N_CACHES), .LW(LW), .CW(CW), .PW(PW)) u_links (
    .clk(clk), .rst_n(rst_n),
    .ent_en(ent_en), .ent_line(ent_line), .ent_idx(ent_idx),
    .ent_fwd(ent_fwd), .ent_bwd(ent_bwd), .ent_mem(ent_mem),
    .fw_en(fw_en), .fw_line(op_line), .fw_idx(fw_idx), .fw_val(fw_val),
    .bw_en(bw_en), .bw_line(op_line), .bw_idx(bw_idx), .bw_val(bw_val),
    .ra_line(rd_line_a), .ra_idx(rd_idx_a),
    .ra_fwd(rd_fwd_a), .ra_bwd(rd_bwd_a), .ra_mem(rd_mem_a),
    .rb_line(q_line), .rb_idx(q_cache),
    .rb_fwd(q_fwd), .rb_bwd(q_bwd), .rb_mem(q_member)
  );

  sl_walker #(.LW(LW), .CW(CW), .PW(PW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(walk_start), .start_line(op_line), .start_head(head_rd),
    .nxt_ptr(rd_fwd_a),
    .busy(walk_busy), .line(walk_line), .cur(walk_cur), .finish(walk_finish)
  );

  assign op_ready    = !walk_busy;
  assign done        = done_q;
  assign visit_valid = walk_busy;
  assign visit_cache = walk_cur;
endmodule

// File: rtl/sl_list_chk.sv
module sl_list_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_kind,
  input logic       op_ready,
  input logic       done,
  input logic       visit_valid,
  input logic       vis_member
);
  assert_visit_member_R7: assert property (@(posedge clk) disable iff (!rst_n)
    visit_valid |-> vis_member);

  assert_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    visit_valid |-> !op_ready);

  assert_done_not_visit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && visit_valid));

  assert_done_after_edit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && (op_kind == 2'b01 || op_kind == 2'b10)) |=> done);

  assert_ready_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_ready) |-> done);

  assert_no_code_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'b00 && op_ready && !visit_valid) |=> !done);
endmodule

bind sl_list_mgr sl_list_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .op_ready(op_ready), .done(done), .visit_valid(visit_valid),
  .vis_member(rd_mem_a)
);

// File: tb/sim_sl_list_mgr.sv
module sim_sl_list_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NL = 4;
  localparam int NULLV = 4;

  logic       clk, rst_n;
  logic       op_valid;
  logic [1:0] op_kind;
  logic [1:0] op_line, op_cache, q_line, q_cache;
  logic       op_ready, done, visit_valid, q_member;
  logic [1:0] visit_cache;
  logic [2:0] q_head, q_fwd, q_bwd;

  int n_chk = 0;
  int n_bad = 0;
  int mlist [NL][NC];
  int mlen  [NL];

  sl_list_mgr #(.N_CACHES(NC), .N_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_line(op_line), .op_cache(op_cache), .op_ready(op_ready), .done(done),
    .visit_valid(visit_valid), .visit_cache(visit_cache),
    .q_line(q_line), .q_cache(q_cache), .q_head(q_head), .q_fwd(q_fwd),
    .q_bwd(q_bwd), .q_member(q_member)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int pos_of(int l, int c);
    for (int i = 0; i < mlen[l]; i++) if (mlist[l][i] == c) return i;
    return -1;
  endfunction

  // compare every line against the bench model; lines not targeted are tagged R11
  task automatic check_all(string tag, int opl);
    for (int l = 0; l < NL; l++) begin
      string t;
      t = (l == opl || opl < 0) ? tag : "R11";
      q_line = 2'(l);
      for (int c = 0; c < NC; c++) begin
        int p, ef, eb;
        q_cache = 2'(c);
        #1;
        p  = pos_of(l, c);
        ef = (p < 0 || p == mlen[l] - 1) ? NULLV : mlist[l][p+1];
        eb = (p <= 0) ? NULLV : mlist[l][p-1];
        if (c == 0) chk(t, $sformatf("head l%0d", l), int'(q_head), (mlen[l] > 0) ? mlist[l][0] : NULLV);
        chk(t, $sformatf("fwd l%0d c%0d", l, c), int'(q_fwd), ef);
        chk(t, $sformatf("bwd l%0d c%0d", l, c), int'(q_bwd), eb);
        chk(t, $sformatf("member l%0d c%0d", l, c), int'(q_member), (p >= 0) ? 1 : 0);
      end
    end
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic do_op(int kind, int l, int c, string tag);
    op_valid = 1'b1;
    op_kind  = 2'(kind);
    op_line  = 2'(l);
    op_cache = 2'(c);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R10", "done after edit", int'(done), 1);
    if (kind == 1 && pos_of(l, c) < 0) begin
      for (int i = mlen[l]; i > 0; i--) mlist[l][i] = mlist[l][i-1];
      mlist[l][0] = c;
      mlen[l]++;
    end else if (kind == 2 && pos_of(l, c) >= 0) begin
      for (int i = pos_of(l, c); i < mlen[l] - 1; i++) mlist[l][i] = mlist[l][i+1];
      mlen[l]--;
    end
    check_all(tag, l);
  endtask

  task automatic do_inval(int l, bit poke);
    int k;
    k = mlen[l];
    op_valid = 1'b1;
    op_kind  = 2'd3;
    op_line  = 2'(l);
    op_cache = 2'd0;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    if (k == 0) begin
      chk("R10", "done empty inval", int'(done), 1);
      chk("R7", "no visit on empty", int'(visit_valid), 0);
    end else begin
      for (int i = 0; i < k; i++) begin
        chk("R7", $sformatf("visit_valid step %0d", i), int'(visit_valid), 1);
        chk("R7", $sformatf("visit_cache step %0d", i), int'(visit_cache), mlist[l][i]);
        chk("R10", "no done mid walk", int'(done), 0);
        chk("R9", "ready low mid walk", int'(op_ready), 0);
        if (poke && i == 0) begin
          op_valid = 1'b1;
          op_kind  = 2'd1;
          op_line  = 2'((l + 1) % NL);
          op_cache = 2'(NC - 1 - ((l + 1) % NC));
        end
        if (i == k - 1) op_valid = 1'b0;
        if (i < k - 1) begin
          @(posedge clk);
          @(negedge clk);
        end
      end
      @(posedge clk);
      @(negedge clk);
      chk("R10", "done after last visit", int'(done), 1);
      chk("R7", "visits stop", int'(visit_valid), 0);
      chk("R10", "ready again", int'(op_ready), 1);
    end
    mlen[l] = 0;
    check_all(poke ? "R9" : "R8", l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_valid = 1'b0; op_kind = 2'd0; op_line = 2'd0; op_cache = 2'd0;
    q_line = 2'd0; q_cache = 2'd0;
    for (int l = 0; l < NL; l++) mlen[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(op_ready), 1);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "visit after reset", int'(visit_valid), 0);
    check_all("R1", -1);

    // R12: code 0 is not accepted
    op_valid = 1'b1; op_kind = 2'd0;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    chk("R12", "no done on code 0", int'(done), 0);
    check_all("R12", -1);

    // R2: fill every line, back to back, with an arithmetic permutation
    for (int l = 0; l < NL; l++)
      for (int j = 0; j < NC; j++) do_op(1, l, (j * 3 + l) % NC, "R2");

    // R3: re-insert existing members
    do_op(1, 0, 1, "R3");
    do_op(1, 2, 0, "R3");
    // R4: delete a middle element, R5: delete the head
    do_op(2, 0, mlist[0][1], "R4");
    do_op(2, 0, mlist[0][0], "R5");
    // R6: delete a non-member
    do_op(2, 0, 1 - 1 + ((mlist[0][0] + 2) % NC == mlist[0][1] ? (mlist[0][0] + 1) % NC : (mlist[0][0] + 2) % NC), "R6");
    // R4: delete the tail, then R5: the sole remaining member
    do_op(2, 0, mlist[0][mlen[0]-1], "R4");
    do_op(2, 0, mlist[0][0], "R5");
    do_op(2, 0, 2, "R6");
    do_op(1, 0, 2, "R2");
    do_op(1, 0, 3, "R2");

    // R7/R8/R9: walk line 1 while an insert to line 2 is offered
    do_inval(1, 1'b1);
    // accept in the same cycle as done, then walk again
    do_op(1, 1, 0, "R2");
    do_inval(2, 1'b0);
    do_inval(3, 1'b1);
    do_inval(0, 1'b0);
    do_inval(0, 1'b0);

    // sweep: per line, insert a varying subset then delete in a varying order
    for (int l = 0; l < NL; l++) begin
      for (int j = 0; j < NC; j++) if (((j + l) % 3) != 0) do_op(1, l, j, "R2");
      for (int j = 0; j < NC; j++) do_op(2, l, (j * 3 + 1) % NC, "R4");
    end
    for (int j = 0; j < NC; j++) do_op(1, 3, j, "R2");
    do_inval(3, 1'b0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule